// File: doc/BRIEF.md
# Banked Edge-Capture Interrupt Vector Controller

This block gathers a wide set of interrupt source lines and splits them into groups of 32 vectors, up to eight groups. Each vector records a rising edge on its source line in a sticky pending bit. The bit stays set until software acknowledges it. Every group has an enable word that gates which pending bits can reach that group's parent interrupt line. Each group drives its own parent line toward an upstream controller.

Software reaches the block through a single-cycle register port. A write of ones into a group's status word acknowledges the matching vectors. The enable words sit in a second bank above the status words. Read data comes back on the clock edge after the read request. The number of implemented groups is a parameter. Register slots for groups that are not built read as zero.

Top module: `ivc_top`

## Requirements
- R1: After reset every pending bit and every enable bit is 0, every parent line is low and the read data bus is zero.
- R2: A rising edge on source line n (a low-to-high change between two consecutive clock samples) sets bit n mod 32 of the status word of group n/32, at byte offset 4*(n/32), on that same clock edge. A line that is held high or falls sets nothing new.
- R3: Writing the status word of group g clears each pending bit whose write data bit is 1. Bits written as 0 keep their value.
- R4: The enable word of group g sits at byte offset 0x20 + 4*g. A written value reads back unchanged. Bit value 1 enables the vector and 0 masks it.
- R5: Parent line g is high exactly when group g has at least one bit that is both pending and enabled. It reflects only group g's vectors. Pending bits still latch while their vector is masked.
- R6: When a new rising edge and an acknowledge write of 1 reach the same vector on the same clock edge, the vector stays pending.
- R7: Read data for a request (valid high, write low) appears on the clock edge that samples the request. After any edge without a read request the read data is zero.
- R8: Byte offsets of 0x40 and above, and offsets whose two low address bits are not 00, are unmapped. They read as zero and ignore writes.
- R9: Status and enable slots of groups at or above the NUM_GROUPS parameter read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32*NUM_GROUPS | Interrupt source lines, vector n on bit n |
| reg_valid | input | 1 | Register access request for this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, one cycle after the request |
| parent_irq | output | NUM_GROUPS | Per-group parent interrupt lines |

## Verification
A source rise set up before a clock edge is captured on that edge. Its pending bit and the parent line change right after that edge, so the bench samples them at the following falling edge. Register writes also take effect on the edge that samples them, and read data lands one edge after the request. The driver issues every access and source change at a falling edge and pushes each expected read word into a queue. A monitor notes read requests on the rising edge and pops and compares them at the next falling edge. Parent lines and the idle read bus are checked directly at the falling edge after the edge that should update them.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam int unsigned VEC_PER_GRP = 32;
   localparam int unsigned MAX_GRP     = 8;
   localparam int unsigned ENA_BASE    = 'h20;
   localparam int unsigned MAP_LIMIT   = 'h40;

   typedef enum logic [1:0] {
      BANK_STAT = 2'd0,
      BANK_ENA  = 2'd1,
      BANK_NONE = 2'd2
   } bank_e;

   typedef struct packed {
      bank_e      bank;
      logic [2:0] idx;
   } reg_sel_t;
endpackage

// File: rtl/ivc_edge_cap.sv
module ivc_edge_cap #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] line_i,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= '0;
      else        last_q <= line_i;
   end

   assign rise_o = line_i & ~last_q;
endmodule

// File: rtl/ivc_group.sv
module ivc_group #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rise_i,
   input  logic             ack_we_i,
   input  logic             ena_we_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] pend_o,
   output logic [WIDTH-1:0] ena_o,
   output logic             irq_o
);
   logic [WIDTH-1:0] pend_q, ena_q, ack_mask;

   assign ack_mask = ack_we_i ? wdata_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         ena_q  <= '0;
      end else begin
         pend_q <= (pend_q & ~ack_mask) | rise_i;
         if (ena_we_i) ena_q <= wdata_i;
      end
   end

   assign pend_o = pend_q;
   assign ena_o  = ena_q;
   assign irq_o  = |(pend_q & ena_q);
endmodule

// File: rtl/ivc_regport.sv
module ivc_regport
   import ivc_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned ADDR_W     = 8,
   localparam int unsigned VW        = NUM_GROUPS * VEC_PER_GRP
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   valid_i,
   input  logic                   write_i,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [VW-1:0]          pend_i,
   input  logic [VW-1:0]          ena_i,
   output logic [NUM_GROUPS-1:0]  ack_we_o,
   output logic [NUM_GROUPS-1:0]  ena_we_o,
   output logic [31:0]            rdata_o
);
   reg_sel_t    sel;
   logic [31:0] rd_val;
   logic        rd_req, wr_req;

   assign rd_req = valid_i && !write_i;
   assign wr_req = valid_i && write_i;

   always_comb begin
      sel.idx  = addr_i[4:2];
      sel.bank = BANK_NONE;
      if (addr_i[1:0] == 2'b00 && addr_i < ADDR_W'(MAP_LIMIT)) begin
         if (addr_i >= ADDR_W'(ENA_BASE)) sel.bank = BANK_ENA;
         else                             sel.bank = BANK_STAT;
      end
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
      assign ack_we_o[g] = wr_req && sel.bank == BANK_STAT && sel.idx == 3'(g);
      assign ena_we_o[g] = wr_req && sel.bank == BANK_ENA  && sel.idx == 3'(g);
   end

   always_comb begin
      rd_val = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (sel.idx == 3'(g)) begin
            if (sel.bank == BANK_STAT)     rd_val = pend_i[g*VEC_PER_GRP +: VEC_PER_GRP];
            else if (sel.bank == BANK_ENA) rd_val = ena_i[g*VEC_PER_GRP +: VEC_PER_GRP];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata_o <= '0;
      else if (rd_req) rdata_o <= rd_val;
      else             rdata_o <= '0;
   end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
   import ivc_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned ADDR_W     = 8,
   localparam int unsigned VW        = NUM_GROUPS * VEC_PER_GRP
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [VW-1:0]         src_i,
   input  logic                  reg_valid,
   input  logic                  reg_write,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   output logic [NUM_GROUPS-1:0] parent_irq
);
   if (NUM_GROUPS < 1 || NUM_GROUPS > MAX_GRP) begin : g_bad_groups
      $error("ivc_top: NUM_GROUPS must lie in 1..8");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ivc_top: ADDR_W must be at least 7");
   end

   logic [VW-1:0]         pend_flat, ena_flat, rise_flat;
   logic [NUM_GROUPS-1:0] ack_we, ena_we;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      ivc_edge_cap #(.WIDTH(VEC_PER_GRP)) u_cap (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (src_i[g*VEC_PER_GRP +: VEC_PER_GRP]),
         .rise_o (rise_flat[g*VEC_PER_GRP +: VEC_PER_GRP])
      );
      ivc_group #(.WIDTH(VEC_PER_GRP)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .rise_i   (rise_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
         .ack_we_i (ack_we[g]),
         .ena_we_i (ena_we[g]),
         .wdata_i  (reg_wdata),
         .pend_o   (pend_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
         .ena_o    (ena_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
         .irq_o    (parent_irq[g])
      );
   end

   ivc_regport #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (reg_valid),
      .write_i  (reg_write),
      .addr_i   (reg_addr),
      .pend_i   (pend_flat),
      .ena_i    (ena_flat),
      .ack_we_o (ack_we),
      .ena_we_o (ena_we),
      .rdata_o  (reg_rdata)
   );
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned ADDR_W     = 8,
   localparam int unsigned VW        = NUM_GROUPS * 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [VW-1:0]         src_i,
   input logic                  reg_valid,
   input logic                  reg_write,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic [31:0]           reg_rdata,
   input logic [NUM_GROUPS-1:0] parent_irq,
   input logic [VW-1:0]         pend,
   input logic [VW-1:0]         ena
);
   // R2
   pend_from_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((pend & ~$past(pend)) & ~$past(src_i)) == '0));

   // R6
   rise_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(src_i) & ~$past(src_i, 2)) & ~pend) == '0));

   // R3
   no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_valid && reg_write && reg_addr < ADDR_W'(8'h20)) |=> (($past(pend) & ~pend) == '0));

   // R5
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ena == '0) |-> (parent_irq == '0));

   // R7
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_valid && !reg_write) |=> (reg_rdata == 32'd0));

   // R8
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_write && (reg_addr >= ADDR_W'(8'h40) || reg_addr[1:0] != 2'b00))
      |=> (ena == $past(ena)));
endmodule

bind ivc_top ivc_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_i      (src_i),
   .reg_valid  (reg_valid),
   .reg_write  (reg_write),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata),
   .parent_irq (parent_irq),
   .pend       (pend_flat),
   .ena        (ena_flat)
);

// File: tb/ivc_top_test.sv
`timescale 1ns/1ps
module ivc_top_test;
   localparam int NG = 6;
   localparam int VW = NG * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [VW-1:0] src = '0;
   logic          reg_valid = 1'b0;
   logic          reg_write = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NG-1:0] parent_irq;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;
   logic rd_due = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   ivc_top #(.NUM_GROUPS(NG), .ADDR_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .src_i(src),
      .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .parent_irq(parent_irq)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      reg_valid = 1'b0;
      reg_write = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: a read sampled on a rising edge is compared at the next falling edge (R7)
   always @(posedge clk) rd_due <= rst_n && reg_valid && !reg_write;

   always @(negedge clk) begin
      if (rd_due) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R7: read data %08h with nothing expected", reg_rdata);
         end else begin
            chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R1 reset state
      chk(32'(parent_irq), 32'd0, "R1 parent lines");
      chk(reg_rdata, 32'd0, "R1 read bus");
      rd(8'h00, 32'd0, "R1 status g0");
      rd(8'h24, 32'd0, "R1 enable g1");
      rd(8'h14, 32'd0, "R1 status g5");
      idle(); idle();
      chk(reg_rdata, 32'd0, "R7 idle bus");

      // R2 pulse on vector 5 while masked; R5 latch while masked
      src[5] = 1'b1; idle(); src[5] = 1'b0; idle();
      chk(32'(parent_irq), 32'd0, "R5 masked vector");
      rd(8'h00, 32'h0000_0020, "R2 vector 5");

      // R4 / R5 enable it
      wr(8'h20, 32'h0000_0020); idle();
      chk(32'(parent_irq), 32'd1, "R5 enabled vector");
      chk(reg_rdata, 32'd0, "R7 after write");
      rd(8'h20, 32'h0000_0020, "R4 readback");

      // R2 held-high line: no new capture after acknowledge
      idle(); src[95] = 1'b1; idle(); idle();
      rd(8'h08, 32'h8000_0000, "R2 vector 95");
      wr(8'h08, 32'h8000_0000);
      idle();
      rd(8'h08, 32'd0, "R2 held line no recapture");
      idle(); src[95] = 1'b0;
      chk(32'(parent_irq), 32'd1, "R5 group isolation");

      // R3 write-one-to-clear
      wr(8'h00, 32'h0000_0001);
      rd(8'h00, 32'h0000_0020, "R3 zero bits kept");
      wr(8'h00, 32'hFFFF_FFFF); idle();
      chk(32'(parent_irq), 32'd0, "R5 after acknowledge");
      rd(8'h00, 32'd0, "R3 full clear");

      // R6 edge and acknowledge together
      idle(); src[103] = 1'b1; idle(); src[103] = 1'b0; idle();
      wr(8'h0C, 32'h0000_0080); src[103] = 1'b1;
      idle(); src[103] = 1'b0;
      rd(8'h0C, 32'h0000_0080, "R6 edge wins");

      // R8 unmapped and misaligned
      wr(8'h40, 32'hFFFF_FFFF);
      wr(8'h60, 32'h0000_0001);
      rd(8'h40, 32'd0, "R8 read 0x40");
      rd(8'hFC, 32'd0, "R8 read 0xFC");
      rd(8'h0F, 32'd0, "R8 misaligned read");
      wr(8'h22, 32'hFFFF_FFFF);
      rd(8'h20, 32'h0000_0020, "R8 misaligned write ignored");
      wr(8'h0D, 32'h0000_0080);
      rd(8'h0C, 32'h0000_0080, "R8 misaligned ack ignored");

      // R9 groups beyond NUM_GROUPS
      wr(8'h38, 32'hFFFF_FFFF);
      rd(8'h38, 32'd0, "R9 enable g6");
      rd(8'h18, 32'd0, "R9 status g6");
      rd(8'h3C, 32'd0, "R9 enable g7");
      rd(8'h1C, 32'd0, "R9 status g7");

      // R5 per-group parent lines
      wr(8'h2C, 32'h0000_0080); idle();
      chk(32'(parent_irq), 32'h08, "R5 group 3 line");
      wr(8'h0C, 32'h0000_0080); idle();
      chk(32'(parent_irq), 32'd0, "R5 group 3 acknowledged");
      wr(8'h34, 32'h8000_0000); src[191] = 1'b1;
      idle(); src[191] = 1'b0;
      chk(32'(parent_irq), 32'h20, "R5 group 5 top vector");
      rd(8'h14, 32'h8000_0000, "R2 vector 191");

      idle(); idle(); idle();
      chk(32'(exp_q.size()), 32'd0, "R7 all reads returned");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule